// File: doc/BRIEF.md
# In-Phase Differential PWM Modulator

This block turns a signed audio sample into two pulse-width-modulated gate-drive signals for the two halves of an H-bridge. When the sample is zero, the two outputs rise and fall together at half duty. The voltage across the load is then zero for the whole period, and no idle current flows through the speaker. Signal polarity is carried by moving the two duties apart in opposite directions around one half. The output with the larger duty stays high over the whole high window of the other output, so the load only sees a voltage during the short time the two differ.

A free-running up/down counter forms a triangular carrier. Its length, and so the switching period, is set by a parameter. Both outputs are compared against this one carrier, so each high pulse is centred on the carrier peak. A new sample, and the state of the mute and disable inputs, is taken only at the carrier wrap. Mute and disable each force both outputs low for whole periods.

Top module: `inphase_pwm_mod`

## Requirements
- R1: After reset both outputs are low, and they stay low through the whole first carrier period (2^(CNT_W+1) clock cycles).
- R2: A zero sample gives both outputs a duty of exactly one half, and the outputs are high in the same cycles.
- R3: For a sample s, let off = s arithmetically shifted right by SAMPLE_W-CNT_W. A positive off gives the positive output 2*(2^(CNT_W-1)+off) high cycles per period and the negative output 2*(2^(CNT_W-1)-off).
- R4: A negative off uses the same formulas, so the positive output has less than half duty and the negative output more than half. A sample of -1 gives off = -1.
- R5: Each output has one high pulse per period, centred on the carrier peak. The pulse starts at period offset 2^CNT_W+1-thr, where thr is the output's high count divided by two. The shorter pulse lies fully inside the longer one.
- R6: off is clamped to the range ±(2^(CNT_W-1)-1), so neither output ever reaches 0% or 100% duty at full-scale input.
- R7: The sample, mute and disable inputs are taken only in the last cycle of a carrier period. Changes at other times do not affect the running period.
- R8: Mute high at the period wrap forces both outputs low for the entire next period.
- R9: Disable high at the period wrap forces both outputs low for the entire next period. When it is released, normal modulation resumes at the following period.
- R10: The carrier is a triangle that steps by one per clock: up from 0 to 2^CNT_W-1, then down to 0. The period is 2^(CNT_W+1) cycles, and output edges repeat at that spacing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_in | input | SAMPLE_W | Signed two's-complement audio sample |
| mute_req | input | 1 | Silences both outputs from the next period |
| drive_off | input | 1 | Turns the bridge drive off from the next period |
| pwm_pos | output | 1 | Gate drive for the positive bridge leg |
| pwm_neg | output | 1 | Gate drive for the negative bridge leg |

## Verification
Samples at zero, at plus and minus a half scale and at plus and minus one step each yield an expected high count, common high count and pulse start for both legs. These values show whether the polarity is right, whether the shift is arithmetic, and whether the pulses are centred. The two full-scale extremes separate a correct clamp from a wrap-around into 0% or 100% duty. Some stimuli change the sample or mute input in the middle of a period. They expose a design that loads at any time rather than only at the wrap. Mute and disable are each applied and released, so their effect must begin and end on period boundaries.

// File: rtl/inphase_pwm_pkg.sv
// Shared definitions for the in-phase PWM modulator.
// Holds the default sizes and the carrier direction type.
package inphase_pwm_pkg;
    localparam int DEF_CNT_W    = 8;
    localparam int DEF_SAMPLE_W = 16;

    typedef enum logic {
        RAMP_UP   = 1'b0,
        RAMP_DOWN = 1'b1
    } ramp_dir_t;
endpackage

// File: rtl/ipm_carrier.sv
// Triangular carrier generator.
// The count runs up from 0 to 2^CNT_W-1, holds one cycle, then runs down to 0
// and holds one cycle, so one period is 2^(CNT_W+1) cycles.
// period_end is high in the last cycle of each period.
// Assumes a synchronous active-low reset.
module ipm_carrier
    import inphase_pwm_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] ramp,
    output logic             period_end
);
    localparam logic [CNT_W-1:0] RAMP_TOP = '1;

    ramp_dir_t dir_q;

    // Advance the triangle one step per clock and turn at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ramp  <= '0;
            dir_q <= RAMP_UP;
        end else begin
            case (dir_q)
                RAMP_UP: begin
                    if (ramp == RAMP_TOP) dir_q <= RAMP_DOWN;
                    else                  ramp  <= ramp + 1'b1;
                end
                default: begin
                    if (ramp == '0) dir_q <= RAMP_UP;
                    else            ramp  <= ramp - 1'b1;
                end
            endcase
        end
    end

    // Mark the final cycle of the period (bottom of the falling slope).
    always_comb period_end = (dir_q == RAMP_DOWN) && (ramp == '0);
endmodule

// File: rtl/ipm_level_map.sv
// Sample-to-threshold mapper.
// It takes the top CNT_W bits of the signed sample as an offset and clamps
// that offset to +-(2^(CNT_W-1)-1). It then returns the half-scale point plus
// the offset for the positive leg and minus the offset for the negative leg.
// Each threshold is the number of high cycles per carrier slope.
// Purely combinational. Assumes SAMPLE_W >= CNT_W.
module ipm_level_map
    import inphase_pwm_pkg::*;
#(
    parameter int CNT_W    = DEF_CNT_W,
    parameter int SAMPLE_W = DEF_SAMPLE_W
) (
    input  logic [SAMPLE_W-1:0] sample,
    output logic [CNT_W-1:0]    thr_pos,
    output logic [CNT_W-1:0]    thr_neg
);
    localparam int                      SHIFT   = SAMPLE_W - CNT_W;
    localparam logic [CNT_W-1:0]        MID     = CNT_W'(2 ** (CNT_W - 1));
    localparam logic signed [CNT_W-1:0] POS_LIM = CNT_W'(2 ** (CNT_W - 1) - 1);
    localparam logic signed [CNT_W-1:0] NEG_LIM = -POS_LIM;

    logic signed [CNT_W-1:0] off_raw;
    logic signed [CNT_W-1:0] off_lim;

    // Pick the coarse offset: a shift when the sample is wider, else a copy.
    generate
        if (SHIFT > 0) begin : g_shift
            always_comb off_raw = CNT_W'($signed(sample) >>> SHIFT);
        end else begin : g_direct
            always_comb off_raw = CNT_W'($signed(sample));
        end
    endgenerate

    // Keep the offset inside the range that never gives 0% or 100% duty.
    always_comb begin
        if (off_raw < NEG_LIM)      off_lim = NEG_LIM;
        else if (off_raw > POS_LIM) off_lim = POS_LIM;
        else                        off_lim = off_raw;
    end

    // Move the two legs in opposite directions from half scale.
    always_comb begin
        thr_pos = MID + off_lim;
        thr_neg = MID - off_lim;
    end
endmodule

// File: rtl/ipm_edge_cmp.sv
// Per-leg carrier comparators with registered outputs.
// A leg is high while ramp >= 2^CNT_W - thr, which makes its pulse centred on
// the carrier peak and 2*thr cycles long. quiet forces all legs low.
// Assumes thr is in 1 .. 2^CNT_W-1.
module ipm_edge_cmp
    import inphase_pwm_pkg::*;
#(
    parameter int CNT_W  = DEF_CNT_W,
    parameter int N_LEGS = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [CNT_W-1:0]             ramp,
    input  logic [N_LEGS-1:0][CNT_W-1:0] thr_vec,
    input  logic                         quiet,
    output logic [N_LEGS-1:0]            leg_out
);
    localparam logic [CNT_W:0] FULL = {1'b1, {CNT_W{1'b0}}};

    generate
        for (genvar g = 0; g < N_LEGS; g++) begin : g_leg
            logic [CNT_W:0] level;

            // Lowest carrier value at which this leg is high.
            always_comb level = FULL - {1'b0, thr_vec[g]};

            // Register the comparison so the gate drive is glitch free.
            always_ff @(posedge clk) begin
                if (!rst_n) leg_out[g] <= 1'b0;
                else        leg_out[g] <= !quiet && ({1'b0, ramp} >= level);
            end
        end
    endgenerate
endmodule

// File: rtl/inphase_pwm_mod.sv
// In-phase differential PWM modulator, top level.
// It loads the mapped thresholds and the quiet state (mute or disable) only
// in the last carrier cycle, so every period runs with one fixed setting.
// Reset starts quiet at half-scale thresholds.
// Assumes a synchronous active-low reset and SAMPLE_W >= CNT_W.
module inphase_pwm_mod
    import inphase_pwm_pkg::*;
#(
    parameter int CNT_W    = DEF_CNT_W,
    parameter int SAMPLE_W = DEF_SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic                mute_req,
    input  logic                drive_off,
    output logic                pwm_pos,
    output logic                pwm_neg
);
    localparam logic [CNT_W-1:0] MID = CNT_W'(2 ** (CNT_W - 1));

    logic [CNT_W-1:0]      ramp;
    logic                  period_end;
    logic [CNT_W-1:0]      next_pos;
    logic [CNT_W-1:0]      next_neg;
    logic [CNT_W-1:0]      thr_pos_q;
    logic [CNT_W-1:0]      thr_neg_q;
    logic                  quiet_q;
    logic [1:0][CNT_W-1:0] thr_vec;
    logic [1:0]            legs;

    ipm_carrier #(.CNT_W(CNT_W)) u_carrier (
        .clk        (clk),
        .rst_n      (rst_n),
        .ramp       (ramp),
        .period_end (period_end)
    );

    ipm_level_map #(.CNT_W(CNT_W), .SAMPLE_W(SAMPLE_W)) u_map (
        .sample  (sample_in),
        .thr_pos (next_pos),
        .thr_neg (next_neg)
    );

    // Take a new setting only at the period wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_pos_q <= MID;
            thr_neg_q <= MID;
            quiet_q   <= 1'b1;
        end else if (period_end) begin
            thr_pos_q <= next_pos;
            thr_neg_q <= next_neg;
            quiet_q   <= mute_req || drive_off;
        end
    end

    // Pack the per-leg thresholds: leg 0 is positive, leg 1 is negative.
    always_comb begin
        thr_vec[0] = thr_pos_q;
        thr_vec[1] = thr_neg_q;
    end

    ipm_edge_cmp #(.CNT_W(CNT_W), .N_LEGS(2)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .ramp    (ramp),
        .thr_vec (thr_vec),
        .quiet   (quiet_q),
        .leg_out (legs)
    );

    // Drive the ports from the registered leg outputs.
    always_comb begin
        pwm_pos = legs[0];
        pwm_neg = legs[1];
    end
endmodule

// File: rtl/ipm_checker.sv
// Property checker for the in-phase PWM modulator, bound to the top level.
module ipm_checker
    import inphase_pwm_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mute_req,
    input logic             drive_off,
    input logic             period_end,
    input logic [CNT_W-1:0] ramp,
    input logic [CNT_W-1:0] thr_pos,
    input logic [CNT_W-1:0] thr_neg,
    input logic             pwm_pos,
    input logic             pwm_neg
);
    localparam logic [CNT_W+1:0] PERIOD   = (CNT_W + 2)'(2 ** (CNT_W + 1));
    localparam logic [CNT_W-1:0] RAMP_TOP = '1;

    logic [CNT_W+1:0] since_rst;
    logic             quiet_seen;

    // Count the cycles since reset, stopping just past one period.
    always_ff @(posedge clk) begin
        if (!rst_n)                since_rst <= '0;
        else if (since_rst <= PERIOD) since_rst <= since_rst + 1'b1;
    end

    // Track the quiet request as it stood at each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)          quiet_seen <= 1'b1;
        else if (period_end) quiet_seen <= mute_req || drive_off;
    end

    a_r1_first_period_low: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst <= PERIOD) |-> (!pwm_pos && !pwm_neg));

    a_r2_equal_in_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_pos == thr_neg) |=> (pwm_pos == pwm_neg));

    a_r5_neg_nested: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_pos >= thr_neg) |=> (!pwm_neg || pwm_pos));

    a_r5_pos_nested: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_neg >= thr_pos) |=> (!pwm_pos || pwm_neg));

    a_r6_duty_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_pos != '0) && (thr_neg != '0));

    a_r7_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
        !period_end |=> ($stable(thr_pos) && $stable(thr_neg)));

    // Covers R8 (mute) and R9 (disable).
    a_r8_quiet_low: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_seen |=> (!pwm_pos && !pwm_neg));

    a_r10_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((ramp != '0) && (ramp != RAMP_TOP)) |=>
            ((ramp == $past(ramp) + 1'b1) || (ramp == $past(ramp) - 1'b1)));
endmodule

bind inphase_pwm_mod ipm_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mute_req   (mute_req),
    .drive_off  (drive_off),
    .period_end (period_end),
    .ramp       (ramp),
    .thr_pos    (thr_pos_q),
    .thr_neg    (thr_neg_q),
    .pwm_pos    (pwm_pos),
    .pwm_neg    (pwm_neg)
);

// File: tb/inphase_pwm_mod_test.sv
// Scoreboard bench. The driver pushes one expected result per carrier period.
// The monitor measures each finished period and compares it with the queue.
module inphase_pwm_mod_test;
    localparam int CNT_W    = 8;
    localparam int SAMPLE_W = 16;
    localparam int PER      = 2 ** (CNT_W + 1);
    localparam int MIDV     = 2 ** (CNT_W - 1);

    typedef struct {
        int    hp;
        int    hn;
        int    both;
        int    rp;
        int    rn;
        string tag;
    } exp_t;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [SAMPLE_W-1:0] sample_in = '0;
    logic                mute_req = 1'b0;
    logic                drive_off = 1'b0;
    logic                pwm_pos;
    logic                pwm_neg;

    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    inphase_pwm_mod uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_in (sample_in),
        .mute_req  (mute_req),
        .drive_off (drive_off),
        .pwm_pos   (pwm_pos),
        .pwm_neg   (pwm_neg)
    );

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic check(string tag, string what, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // Expected per-period result, built from R3-R6 and R8/R9.
    function automatic exp_t model(logic [SAMPLE_W-1:0] s, bit quiet, string tag);
        exp_t e;
        int   off;
        int   tp;
        int   tn;
        off = int'($signed(s)) >>> (SAMPLE_W - CNT_W);
        if (off < -(MIDV - 1)) off = -(MIDV - 1);
        if (off > MIDV - 1)    off = MIDV - 1;
        tp = MIDV + off;
        tn = MIDV - off;
        e.tag = tag;
        if (quiet) begin
            e.hp = 0; e.hn = 0; e.both = 0; e.rp = 0; e.rn = 0;
        end else begin
            e.hp   = 2 * tp;
            e.hn   = 2 * tn;
            e.both = 2 * ((tp < tn) ? tp : tn);
            e.rp   = PER / 2 + 1 - tp;
            e.rn   = PER / 2 + 1 - tn;
        end
        return e;
    endfunction

    // Driver: early values at the start of a period, optional final values mid-period.
    task automatic apply(logic [SAMPLE_W-1:0] s, bit m, bit d,
                         bit mid, logic [SAMPLE_W-1:0] s_e, bit m_e, bit d_e,
                         string tag);
        do @(negedge clk); while (cyc % PER != 1);
        if (mid) begin
            sample_in = s_e; mute_req = m_e; drive_off = d_e;
            do @(negedge clk); while (cyc % PER != 300);
        end
        sample_in = s; mute_req = m; drive_off = d;
        exp_q.push_back(model(s, m || d, tag));
    endtask

    // Monitor: measure each period and compare it with the scoreboard.
    int cp = 0, cn = 0, cb = 0, rp = 0, rn = 0;
    logic prev_p = 1'b0, prev_n = 1'b0;
    always @(negedge clk) begin
        if (rst_n && cyc > 0) begin
            int j;
            j = (cyc - 1) % PER + 1;
            cp += int'(pwm_pos);
            cn += int'(pwm_neg);
            cb += int'(pwm_pos && pwm_neg);
            if (pwm_pos && !prev_p && rp == 0) rp = j;
            if (pwm_neg && !prev_n && rn == 0) rn = j;
            prev_p = pwm_pos;
            prev_n = pwm_neg;
            if (j == PER) begin
                if (exp_q.size() == 0) begin
                    check("R10", "missing expectation", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(e.tag, "pos high cycles", cp, e.hp);
                    check(e.tag, "neg high cycles", cn, e.hn);
                    check(e.tag, "R5 common high cycles", cb, e.both);
                    check(e.tag, "R5/R10 pos pulse start", rp, e.rp);
                    check(e.tag, "R5/R10 neg pulse start", rn, e.rn);
                end
                cp = 0; cn = 0; cb = 0; rp = 0; rn = 0;
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog R10 actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1", "pos low in reset", int'(pwm_pos), 0);
        check("R1", "neg low in reset", int'(pwm_neg), 0);
        exp_q.push_back(model('0, 1'b1, "R1"));
        rst_n = 1'b1;

        apply(16'h0000, 0, 0, 0, '0, 0, 0, "R2");
        apply(16'h4000, 0, 0, 0, '0, 0, 0, "R3");
        apply(16'hC000, 0, 0, 0, '0, 0, 0, "R4");
        apply(16'h0100, 0, 0, 0, '0, 0, 0, "R3");
        apply(16'hFFFF, 0, 0, 0, '0, 0, 0, "R4");
        apply(16'h7FFF, 0, 0, 0, '0, 0, 0, "R6");
        apply(16'h8000, 0, 0, 0, '0, 0, 0, "R6");
        apply(16'hE000, 0, 0, 1, 16'h4000, 0, 0, "R7");
        apply(16'h2000, 1, 0, 1, 16'h2000, 0, 0, "R8");
        apply(16'h5000, 1, 0, 0, '0, 0, 0, "R8");
        apply(16'h2000, 0, 0, 1, 16'h2000, 1, 1, "R7");
        apply(16'h3000, 0, 1, 0, '0, 0, 0, "R9");
        apply(16'h1000, 0, 0, 0, '0, 0, 0, "R9");
        apply(16'h0000, 0, 0, 0, '0, 0, 0, "R10");
        apply(16'h0000, 0, 0, 0, '0, 0, 0, "R2");

        while (exp_q.size() != 0) @(negedge clk);
        finish_run();
    end
endmodule